// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a clocked front end for an external asynchronous static RAM of 65,536 sixteen-bit words. A client hands it one access at a time (read or write) carrying a word address, write data and a two-bit lane mask. The controller drives the memory's active-low select, write strobe, output enable and two lane enables. It also steers a tri-state driver on the shared 16-bit data bus. Every phase of the access is stretched over a parameterised number of clock cycles, so that the memory's access, pulse-width, setup and bus-turnaround times are met at the chosen clock rate.

The request side is a valid/ready stream. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` stays low from that edge until the access has finished, so the client applies back-pressure simply by holding its request. Only one access is ever in flight. The response side is a single-cycle `rsp_valid` pulse with no back-pressure: the client must take the read word in the cycle it appears. Writes produce no response.

A write keeps output enable high and pulls select and write strobe low. It leaves the bus driver off until the memory's outputs have had time to float, then drives data for the setup window. All strobes rise together, and the driver is held for one more cycle as data hold.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset and whenever no access is in progress, `req_ready` is 1, all five active-low strobes are 1 and `bus_drive` is 0.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the edge after acceptance until the access ends, and a request held valid while busy is accepted exactly once.
- R3: Mask bit 0 enables the lower lane (data bits 7:0, pin `mem_lo_n`) and mask bit 1 enables the upper lane (bits 15:8, pin `mem_hi_n`). While select is low, an enabled lane's pin is 0 and a disabled lane's pin stays 1, so a disabled lane is neither written nor read. A write with mask 00 leaves the word unchanged.
- R4: A write holds `mem_cs_n` and `mem_we_n` low with `mem_oe_n` high for exactly TURN_CYC + DATA_CYC cycles, and `mem_we_n` is never low without `mem_cs_n` low.
- R5: During a write, `bus_drive` stays 0 for the first TURN_CYC cycles of the write strobe and is 1 for the remaining DATA_CYC cycles before the strobe rises.
- R6: `mem_we_n`, `mem_cs_n` and the lane enables rise on the same edge. `bus_drive` stays 1 for exactly one cycle after that edge and is 0 in the following cycle.
- R7: A read holds `mem_cs_n` and `mem_oe_n` low with `mem_we_n` high for exactly RD_CYC cycles. The bus is sampled at the end of the last of them, and `rsp_valid` pulses in the first cycle after `mem_oe_n` rises. Bits of a disabled lane in `rsp_rdata` read 0.
- R8: `bus_drive` is never 1 while `mem_oe_n` is 0.
- R9: Throughout an access, `mem_addr` equals the accepted address. While driving, `bus_out` equals the accepted write data.
- R10: Each accepted read gives exactly one single-cycle `rsp_valid` pulse, and writes give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lo_n | output | 1 | Lower lane enable, active low |
| mem_hi_n | output | 1 | Upper lane enable, active low |
| bus_out | output | 16 | Data toward the tri-state driver |
| bus_drive | output | 1 | Tri-state driver enable |
| bus_in | input | 16 | Data seen on the shared bus |

## Verification
The hardest property to reach from the ports is that a disabled lane keeps its old contents through a masked write. It is seen only by reading the word back later. The bench therefore models the memory with its own store, which commits only the enabled lanes and only at the edge that ends the write. It then reads full words after lower-only, upper-only and empty-mask writes to the same address. Bus contention and the turnaround window are watched every cycle by a monitor that counts write-strobe cycles against the driver enable. The controller is built with turnaround, data and read windows longer than one cycle, so that an off-by-one in any phase shows up. Requests are issued back to back, with valid raised while the controller is still busy, to exercise the single-acceptance rule.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WTURN = 3'd1,
    ST_WDATA = 3'd2,
    ST_WEND  = 3'd3,
    ST_RWAIT = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic       cs_n;
    logic       we_n;
    logic       oe_n;
    logic [1:0] lane_n;
    logic       drive;
  } strobe_t;

  localparam strobe_t STROBE_REST = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                      lane_n: 2'b11, drive: 1'b0};

  // Pin levels wanted while the sequencer sits in a given state.
  function automatic strobe_t strobe_for(input seq_state_t s, input logic [1:0] mask);
    strobe_t r;
    r = STROBE_REST;
    case (s)
      ST_WTURN: begin
        r.cs_n = 1'b0; r.we_n = 1'b0; r.lane_n = ~mask;
      end
      ST_WDATA: begin
        r.cs_n = 1'b0; r.we_n = 1'b0; r.lane_n = ~mask; r.drive = 1'b1;
      end
      ST_WEND: begin
        r.drive = 1'b1;
      end
      ST_RWAIT: begin
        r.cs_n = 1'b0; r.oe_n = 1'b0; r.lane_n = ~mask;
      end
      default: r = STROBE_REST;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int TURN_CYC = 1,
  parameter int DATA_CYC = 1,
  parameter int RD_CYC   = 2,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_mask,
  input  logic [1:0]       mask_q,
  input  logic             timer_done,
  output logic             req_ready,
  output logic             fire,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output strobe_t          strobe_q
);

  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] DATA_LD = CNT_W'(DATA_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);

  seq_state_t state_q, nxt;
  logic [1:0] mask_sel;

  assign req_ready = (state_q == ST_IDLE);
  assign fire      = req_valid && req_ready;
  assign mask_sel  = fire ? req_mask : mask_q;

  always_comb begin
    nxt      = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fire) begin
          tmr_load = 1'b1;
          if (req_write) begin
            nxt     = ST_WTURN;
            tmr_val = TURN_LD;
          end else begin
            nxt     = ST_RWAIT;
            tmr_val = RD_LD;
          end
        end
      end
      ST_WTURN: begin
        if (timer_done) begin
          nxt      = ST_WDATA;
          tmr_load = 1'b1;
          tmr_val  = DATA_LD;
        end
      end
      ST_WDATA: if (timer_done) nxt = ST_WEND;
      ST_WEND:  nxt = ST_IDLE;
      ST_RWAIT: begin
        if (timer_done) begin
          nxt     = ST_IDLE;
          capture = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      strobe_q <= STROBE_REST;
    end else begin
      state_q  <= nxt;
      strobe_q <= strobe_for(nxt, mask_sel);
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !req_ready);

  // R7
  read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!strobe_q.oe_n && strobe_q.we_n));

endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] bus_out,
  output logic [LANES-1:0]  mask_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] lane_keep;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_keep[l*LANE_W +: LANE_W] = {LANE_W{mask_q[l]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      bus_out  <= '0;
      mask_q   <= '0;
    end else if (fire) begin
      mem_addr <= req_addr;
      bus_out  <= req_wdata;
      mask_q   <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= bus_in & lane_keep;
    end
  end

  // R10
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int TURN_CYC = 1,
  parameter int DATA_CYC = 1,
  parameter int RD_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lo_n,
  output logic              mem_hi_n,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_drive,
  input  logic [DATA_W-1:0] bus_in
);

  localparam int MAX_A = (TURN_CYC > DATA_CYC) ? TURN_CYC : DATA_CYC;
  localparam int MAX_C = (MAX_A > RD_CYC) ? MAX_A : RD_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             fire, capture, tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic [1:0]       mask_q;
  strobe_t          strobe_q;

  sram_lane_seq #(
    .TURN_CYC(TURN_CYC), .DATA_CYC(DATA_CYC), .RD_CYC(RD_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mask(req_mask), .mask_q(mask_q), .timer_done(tmr_done),
    .req_ready(req_ready), .fire(fire), .capture(capture),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .strobe_q(strobe_q)
  );

  sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  sram_lane_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(2)) u_dp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .bus_in(bus_in), .mem_addr(mem_addr), .bus_out(bus_out), .mask_q(mask_q),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign mem_cs_n  = strobe_q.cs_n;
  assign mem_we_n  = strobe_q.we_n;
  assign mem_oe_n  = strobe_q.oe_n;
  assign mem_lo_n  = strobe_q.lane_n[0];
  assign mem_hi_n  = strobe_q.lane_n[1];
  assign bus_drive = strobe_q.drive;

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> mem_oe_n);

  // R4
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

  // R5
  float_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !bus_drive);

  // R6
  hold_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (bus_drive && mem_cs_n && mem_lo_n && mem_hi_n));

  // R6
  driver_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && mem_we_n) |=> !bus_drive);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !bus_drive));

endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TB_TURN = 2;
  localparam int TB_DATA = 3;
  localparam int TB_RD   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid, bus_drive;
  logic [15:0] rsp_rdata, mem_addr, bus_out;
  logic [15:0] bus_in = 16'hA5A5;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl #(.TURN_CYC(TB_TURN), .DATA_CYC(TB_DATA), .RD_CYC(TB_RD)) u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n),
    .bus_out(bus_out), .bus_drive(bus_drive), .bus_in(bus_in)
  );

  int checks = 0;
  int errors = 0;
  int reads_issued = 0;
  int rsp_seen = 0;

  logic [15:0] bmem [int];    // memory model contents
  logic [15:0] shadow [int];  // expected contents
  logic [15:0] exp_q [$];

  logic [15:0] cur_addr = '0, cur_wdata = '0;
  logic [1:0]  cur_mask = '0;
  bit          monitor_on = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input logic [15:0] a, input bit from_model);
    if (from_model) return bmem.exists(int'(a)) ? bmem[int'(a)] : 16'h0000;
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
  endfunction

  // Monitor and memory model, all sampled away from the active edge.
  int          we_cnt = 0, rd_cnt = 0;
  bit          prev_we_low = 1'b0, rel_pending = 1'b0;
  logic        prev_lo_n = 1'b1, prev_hi_n = 1'b1;
  logic [15:0] w, expv;

  always @(negedge clk) begin
    if (rst_n && monitor_on) begin
      if (bus_drive && !mem_oe_n) chk(1'b0, "R8 drive while oe low", 1, 0);
      if (!mem_cs_n) begin
        chk(!req_ready, "R2 ready low while busy", req_ready, 0);
        chk(mem_lo_n == ~cur_mask[0] && mem_hi_n == ~cur_mask[1], "R3 lane pins",
            {mem_hi_n, mem_lo_n}, ~cur_mask);
        chk(mem_addr == cur_addr, "R9 address held", mem_addr, cur_addr);
      end
      if (rel_pending) begin
        chk(!bus_drive, "R6 driver released", bus_drive, 0);
        rel_pending = 1'b0;
      end
      if (!mem_we_n) begin
        we_cnt++;
        chk(mem_oe_n == 1'b1, "R4 oe high in write", mem_oe_n, 1);
        if (we_cnt <= TB_TURN) chk(!bus_drive, "R5 no drive in turnaround", bus_drive, 0);
        else chk(bus_drive, "R5 drive in data window", bus_drive, 1);
      end else if (prev_we_low) begin
        chk(we_cnt == TB_TURN + TB_DATA, "R4 write strobe width", we_cnt, TB_TURN + TB_DATA);
        chk(bus_drive && mem_cs_n && mem_lo_n && mem_hi_n, "R6 hold cycle",
            {bus_drive, mem_cs_n, mem_lo_n, mem_hi_n}, 4'b1111);
        chk(bus_out == cur_wdata, "R9 write data", bus_out, cur_wdata);
        w = word_of(mem_addr, 1'b1);
        if (!prev_lo_n) w[7:0]  = bus_out[7:0];
        if (!prev_hi_n) w[15:8] = bus_out[15:8];
        bmem[int'(mem_addr)] = w;
        we_cnt = 0;
        rel_pending = 1'b1;
      end
      if (!mem_oe_n) begin
        rd_cnt++;
        chk(mem_we_n, "R7 we high in read", mem_we_n, 1);
      end
      if (rsp_valid) begin
        rsp_seen++;
        chk(rd_cnt == TB_RD, "R7 read window", rd_cnt, TB_RD);
        chk(mem_oe_n, "R7 pulse after oe rises", mem_oe_n, 1);
        rd_cnt = 0;
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected response", rsp_rdata, 0);
        else begin
          expv = exp_q.pop_front();
          chk(rsp_rdata == expv, "R7 read data", rsp_rdata, expv);
        end
      end
    end
    prev_we_low = !mem_we_n;
    prev_lo_n   = mem_lo_n;
    prev_hi_n   = mem_hi_n;
    // memory drives only enabled lanes of a read
    bus_in = 16'hA5A5;
    if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
      w = word_of(mem_addr, 1'b1);
      if (!mem_lo_n) bus_in[7:0]  = w[7:0];
      if (!mem_hi_n) bus_in[15:8] = w[15:8];
    end
  end

  // Driver: holds valid until an edge where ready is high.
  task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] s;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    cur_addr = a; cur_wdata = d; cur_mask = m;
    s = word_of(a, 1'b0);
    if (wr) begin
      if (m[0]) s[7:0]  = d[7:0];
      if (m[1]) s[15:8] = d[15:8];
      shadow[int'(a)] = s;
    end else begin
      exp_q.push_back(s & {{8{m[1]}}, {8{m[0]}}});
      reads_issued++;
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && mem_cs_n && mem_we_n && mem_oe_n && mem_lo_n && mem_hi_n && !bus_drive && !rsp_valid,
        "R1 reset state",
        {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n, bus_drive, rsp_valid}, 8'b11111100);
    monitor_on = 1'b1;

    issue(1'b1, 16'h0010, 16'h1234, 2'b11);
    issue(1'b0, 16'h0010, 16'h0000, 2'b11);
    issue(1'b1, 16'h0010, 16'hFFCD, 2'b01);   // R3 lower only
    issue(1'b0, 16'h0010, 16'h0000, 2'b11);
    issue(1'b1, 16'h0010, 16'h77EE, 2'b10);   // R3 upper only
    issue(1'b0, 16'h0010, 16'h0000, 2'b11);
    issue(1'b1, 16'h0010, 16'h0000, 2'b00);   // R3 empty mask leaves word
    issue(1'b0, 16'h0010, 16'h0000, 2'b11);
    issue(1'b0, 16'h0010, 16'h0000, 2'b01);   // R7 masked reads
    issue(1'b0, 16'h0010, 16'h0000, 2'b10);
    issue(1'b0, 16'h0010, 16'h0000, 2'b00);
    go_idle();
    // R1 idle state between accesses
    chk(req_ready && mem_cs_n && mem_oe_n && !bus_drive, "R1 idle state",
        {req_ready, mem_cs_n, mem_oe_n, bus_drive}, 4'b1110);

    issue(1'b1, 16'h0000, 16'hC0DE, 2'b11);   // R9 address boundaries
    issue(1'b1, 16'hFFFF, 16'hBEEF, 2'b11);
    issue(1'b0, 16'h0000, 16'h0000, 2'b11);
    issue(1'b0, 16'hFFFF, 16'h0000, 2'b11);
    for (int i = 0; i < 8; i++) issue(1'b1, 16'h0100 + 16'(i * 37), 16'h1111 * 16'(i + 1), 2'(i % 4));
    for (int i = 0; i < 8; i++) issue(1'b0, 16'h0100 + 16'(i * 37), 16'h0000, 2'b11);
    go_idle();

    // R10 one response per read, none for writes
    chk(rsp_seen == reads_issued, "R10 response count", rsp_seen, reads_issued);
    chk(exp_q.size() == 0, "R10 no pending reads", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule